// File: doc/BRIEF.md
# Timer Match Action Controller

The block is a free-running 32-bit timer with a programmable prescaler and four match channels. An external prescale tick input drives a prescale counter. Each time that counter reaches its programmed limit, it wraps and the timer counter advances by one. On every such advance, each match channel compares its match value against the current timer count. A match can take any mix of three actions: set a sticky interrupt flag, return the timer to zero, or halt the timer and clear its run-enable bit.

Software reaches the block through a flat register port. There is a write strobe with a 4-bit word address and 32-bit data, and a combinational read port with its own address. The register map is as follows:

| Address | Content |
|---------|---------|
| 0 | Timer control |
| 1 | Prescale limit |
| 2 | Match control word |
| 3 | Interrupt flags |
| 4..7 | Match values 0..3 |
| 8 | Timer counter (read-only) |
| 9 | Prescale counter (read-only) |

Each channel drives its own interrupt line, and a combined line is the OR of all channel lines.

Top module: `timer_match_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and every interrupt output reads 0. This covers the control register, the prescale limit, the match control word, the flags, the match values, the timer counter and the prescale counter.
- R2: While the timer runs, each cycle with `tick_in` high steps the prescale counter (address 9). On the tick where the prescale counter equals the prescale limit P (address 1), the prescale counter returns to 0 and the timer counter (address 8) advances. The timer therefore advances once every P+1 ticks. Cycles with `tick_in` low change nothing.
- R3: Control register bit 0 is run-enable. Bit 1 is a hold-clear that keeps both counters at 0 while it is set. With run-enable at 0, neither counter moves on ticks.
- R4: On an advance where the timer counter equals match value i (address 4+i), and bit 3i of the match control word is set, interrupt flag i (bit i of address 3) becomes 1 and stays 1.
- R5: On an advance where channel i matches and bit 3i+1 is set, the timer counter becomes 0 instead of incrementing.
- R6: On an advance where channel i matches and bit 3i+2 is set, the timer counter holds its value and the prescale counter is left at 0. Control bit 0 reads 0 afterwards, and later ticks move neither counter.
- R7: When a matching channel has both its reset bit and its stop bit set, the timer counter becomes 0 and halts in the same cycle. Its interrupt bit still applies.
- R8: Bits 31:12 of the match control word ignore writes and read 0. Bits 11:0 read back as written.
- R9: Writing 1 to a flag bit at address 3 clears that flag, and writing 0 leaves it unchanged. `irq_ch[i]` equals flag i, and `irq` is the OR of the flags.
- R10: The channels act independently. Several channels that match on the same advance each set their own flag.
- R11: The match values and the prescale limit read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| tick_in | input | 1 | Prescale tick, one step per high cycle |
| irq_ch | output | 4 | Per-channel sticky interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench checks the exact number of ticks per advance with a nonzero prescale limit. An off-by-one compare in the prescaler would advance one tick early or late. Stop-on-match is checked mid-prescale. A design that left the prescale counter running, or kept run-enable set, would show a nonzero prescale count or a moving timer on later ticks. The combined reset-and-stop case has to land on 0 and stay there, and a simultaneous two-channel match must raise both flags rather than only the highest-priority one. Write-one-to-clear is tested with a zero write first, so a design that clears on any write is caught.

// File: rtl/tmr_pkg.sv
// Package: shared offsets and the per-channel action field layout.
// Assumes the word-address register map described in the brief.
package tmr_pkg;
    localparam int ADR_CTRL  = 0;
    localparam int ADR_PRE   = 1;
    localparam int ADR_MCTL  = 2;
    localparam int ADR_FLAGS = 3;
    localparam int ADR_MR0   = 4;
    localparam int ACT_BITS  = 3;

    // Per-channel action field: bit 0 interrupt, bit 1 clear, bit 2 halt.
    typedef struct packed {
        logic halt;
        logic clr;
        logic irq;
    } ch_act_t;
endpackage

// File: rtl/tmr_prescale.sv
// Prescale counter: counts ticks while running and flags an advance
// when the count reaches the limit. Assumes clr overrides everything.
module tmr_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pc,
    output logic         adv
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Advance when the count has reached (or passed) the limit.
    assign adv = run && tick && !clr && (pc >= limit);

    // Count ticks; wrap to zero on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc <= '0;
        end else if (run && tick) begin
            pc <= adv ? '0 : pc + ONE;
        end
    end

    // R2: a running tick below the limit steps the count by one.
    assert_pc_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && tick && !clr && (pc < limit)) |-> pc == $past(pc) + ONE);
endmodule

// File: rtl/tmr_match_bank.sv
// Match bank: compares every channel's match value to the counter on an
// advance and gathers the enabled actions. Assumes adv is one cycle wide.
module tmr_match_bank
    import tmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int NUM_CH = 4
) (
    input  logic [W-1:0]                tc,
    input  logic                        adv,
    input  logic [NUM_CH-1:0][W-1:0]    mr,
    input  ch_act_t [NUM_CH-1:0]        act,
    output logic [NUM_CH-1:0]           irq_hit,
    output logic                        any_clr,
    output logic                        any_halt
);
    logic [NUM_CH-1:0] clr_hit;
    logic [NUM_CH-1:0] halt_hit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic eq;
        // Equality is only meaningful on the advancing cycle.
        assign eq          = adv && (tc == mr[i]);
        assign irq_hit[i]  = eq && act[i].irq;
        assign clr_hit[i]  = eq && act[i].clr;
        assign halt_hit[i] = eq && act[i].halt;
    end

    assign any_clr  = |clr_hit;
    assign any_halt = |halt_hit;
endmodule

// File: rtl/tmr_irq_flags.sv
// Sticky interrupt flags: set by match hits, cleared by write-one.
// Assumes a set and a clear on the same cycle leave the flag set.
module tmr_irq_flags #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic [NUM_CH-1:0] clr,
    output logic [NUM_CH-1:0] flags
);
    // Hold each flag until software clears it; a new hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: a hit always leaves its flag raised.
        assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(set[i]) |-> flags[i]);
        // R9: without hit or clear a flag keeps its value.
        assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!set[i] && !clr[i]) |-> flags[i] == $past(flags[i]));
    end
endmodule

// File: rtl/timer_match_ctrl.sv
// Timer with prescaler and match channels that can interrupt, clear or
// halt the counter. Assumes a single write port and a combinational read.
module timer_match_ctrl
    import tmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = $clog2(NUM_CH + 6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              tick_in,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq
);
    localparam int CTL_W = ACT_BITS * NUM_CH;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(ADR_PRE);
    localparam logic [ADDR_W-1:0] A_MCTL  = ADDR_W'(ADR_MCTL);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_FLAGS);
    localparam logic [ADDR_W-1:0] A_TC    = ADDR_W'(ADR_MR0 + NUM_CH);
    localparam logic [ADDR_W-1:0] A_PC    = ADDR_W'(ADR_MR0 + NUM_CH + 1);
    localparam logic [W-1:0]      ONE     = {{(W-1){1'b0}}, 1'b1};

    logic                     run_en;
    logic                     clr_hold;
    logic [W-1:0]             pre_lim;
    logic [CTL_W-1:0]         mctl;
    logic [NUM_CH-1:0][W-1:0] mr;
    logic [W-1:0]             tc;
    logic [W-1:0]             pc;
    logic                     adv;
    logic [NUM_CH-1:0]        irq_hit;
    logic                     any_clr;
    logic                     any_halt;
    logic [NUM_CH-1:0]        flag_clr;
    logic [NUM_CH-1:0]        flags;
    logic                     wr_ctrl;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign flag_clr = (wr_en && (wr_addr == A_FLAGS)) ? wr_data[NUM_CH-1:0] : '0;

    // Control register: software write wins over a hardware halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            clr_hold <= 1'b0;
        end else if (wr_ctrl) begin
            run_en   <= wr_data[0];
            clr_hold <= wr_data[1];
        end else if (adv && any_halt) begin
            run_en   <= 1'b0;
        end
    end

    // Prescale limit and match control word (reserved bits not stored).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_lim <= '0;
            mctl    <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PRE)  pre_lim <= wr_data;
            if (wr_addr == A_MCTL) mctl    <= wr_data[CTL_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_mr
        localparam logic [ADDR_W-1:0] A_MR = ADDR_W'(ADR_MR0 + i);
        // Match value i: loaded by a write to its own address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mr[i] <= '0;
            end else if (wr_en && (wr_addr == A_MR)) begin
                mr[i] <= wr_data;
            end
        end
    end

    tmr_prescale #(.W(W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .tick  (tick_in),
        .clr   (clr_hold),
        .limit (pre_lim),
        .pc    (pc),
        .adv   (adv)
    );

    tmr_match_bank #(.W(W), .NUM_CH(NUM_CH)) u_match (
        .tc       (tc),
        .adv      (adv),
        .mr       (mr),
        .act      (mctl),
        .irq_hit  (irq_hit),
        .any_clr  (any_clr),
        .any_halt (any_halt)
    );

    tmr_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_hit),
        .clr   (flag_clr),
        .flags (flags)
    );

    // Timer counter: clear wins, then hold on halt, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_hold) begin
            tc <= '0;
        end else if (adv) begin
            if (any_clr)       tc <= '0;
            else if (!any_halt) tc <= tc + ONE;
        end
    end

    assign irq_ch = flags;
    assign irq    = |flags;

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[0] = run_en;
            rd_data[1] = clr_hold;
        end
        if (rd_addr == A_PRE)   rd_data = pre_lim;
        if (rd_addr == A_MCTL)  rd_data[CTL_W-1:0] = mctl;
        if (rd_addr == A_FLAGS) rd_data[NUM_CH-1:0] = flags;
        if (rd_addr == A_TC)    rd_data = tc;
        if (rd_addr == A_PC)    rd_data = pc;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(ADR_MR0 + i)) rd_data = mr[i];
        end
    end

    // R6: a halting match with no control write drops run-enable.
    assert_halt_drops_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && any_halt && !wr_ctrl) |-> !run_en);
    // R5: a clearing match sends the counter to zero.
    assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && any_clr && !clr_hold) |-> tc == '0);
    // R3: a stopped timer keeps its count.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_en && !clr_hold) |-> tc == $past(tc));
    // R7: clear plus halt leaves zero and a stopped timer.
    assert_clear_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv && any_clr && any_halt && !wr_ctrl && !clr_hold) |-> (tc == '0) && !run_en);
endmodule

// File: tb/tb_timer_match_ctrl.sv
module tb_timer_match_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick_in = 1'b0;
    logic [3:0]  irq_ch;
    logic        irq;
    int checks = 0;
    int errors = 0;

    timer_match_ctrl dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    // Restart the timer cleanly with prescale p and control word m.
    task automatic restart(input logic [31:0] p, input logic [31:0] m);
        wr(4'd0, 32'h2);
        wr(4'd1, p);
        wr(4'd2, m);
        wr(4'd3, 32'hF);
        wr(4'd0, 32'h1);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 10; a++) rd_chk("R1 reset reg", 4'(a), 32'h0);
        chk("R1 irq_ch", {28'h0, irq_ch}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_readback();
        wr(4'd4, 32'hDEAD_0001);
        wr(4'd7, 32'h1234_5678);
        rd_chk("R11 match0", 4'd4, 32'hDEAD_0001);
        rd_chk("R11 match3", 4'd7, 32'h1234_5678);
        wr(4'd1, 32'h0000_00A5);
        rd_chk("R11 prescale", 4'd1, 32'hA5);
        wr(4'd2, 32'hFFFF_FFFF);
        rd_chk("R8 reserved bits", 4'd2, 32'h0000_0FFF);
        wr(4'd2, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd7, 32'h0);
    endtask

    task automatic t_prescale();
        restart(32'd2, 32'h0);
        ticks(1);
        rd_chk("R2 pc after 1 tick", 4'd9, 32'd1);
        rd_chk("R2 tc after 1 tick", 4'd8, 32'd0);
        ticks(2);
        rd_chk("R2 tc after 3 ticks", 4'd8, 32'd1);
        repeat (5) @(negedge clk);
        rd_chk("R2 no tick no change", 4'd8, 32'd1);
        ticks(6);
        rd_chk("R2 tc after 9 ticks", 4'd8, 32'd3);
    endtask

    task automatic t_enable();
        wr(4'd0, 32'h0);
        ticks(6);
        rd_chk("R3 disabled tc holds", 4'd8, 32'd3);
        wr(4'd0, 32'h2);
        rd_chk("R3 hold-clear tc", 4'd8, 32'd0);
        rd_chk("R3 hold-clear pc", 4'd9, 32'd0);
    endtask

    task automatic t_irq();
        wr(4'd4, 32'd2);
        restart(32'd0, 32'h001);
        ticks(2);
        rd_chk("R4 no flag before match", 4'd3, 32'h0);
        ticks(1);
        rd_chk("R4 flag after match", 4'd3, 32'h1);
        chk("R9 irq_ch", {28'h0, irq_ch}, 32'h1);
        chk("R9 irq", {31'h0, irq}, 32'h1);
        wr(4'd3, 32'h0);
        rd_chk("R9 zero write keeps", 4'd3, 32'h1);
        wr(4'd3, 32'h1);
        rd_chk("R9 one write clears", 4'd3, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_clear_match();
        wr(4'd5, 32'd3);
        restart(32'd0, 32'h010);
        ticks(4);
        rd_chk("R5 tc wraps to 0", 4'd8, 32'd0);
        ticks(1);
        rd_chk("R5 tc counts again", 4'd8, 32'd1);
        chk("R5 no irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_halt();
        wr(4'd6, 32'd2);
        restart(32'd1, 32'h100);
        ticks(5);
        rd_chk("R6 tc before halt", 4'd8, 32'd2);
        ticks(1);
        rd_chk("R6 tc halted", 4'd8, 32'd2);
        rd_chk("R6 run cleared", 4'd0, 32'd0);
        rd_chk("R6 pc zero", 4'd9, 32'd0);
        ticks(4);
        rd_chk("R6 tc stays", 4'd8, 32'd2);
        rd_chk("R6 pc stays", 4'd9, 32'd0);
    endtask

    task automatic t_both();
        wr(4'd7, 32'd1);
        restart(32'd0, 32'hE00);
        ticks(2);
        rd_chk("R7 tc zero", 4'd8, 32'd0);
        rd_chk("R7 run cleared", 4'd0, 32'd0);
        rd_chk("R7 flag3", 4'd3, 32'h8);
        ticks(3);
        rd_chk("R7 stays zero", 4'd8, 32'd0);
    endtask

    task automatic t_multi();
        wr(4'd4, 32'd1);
        wr(4'd5, 32'd1);
        wr(4'd6, 32'd7);
        wr(4'd7, 32'd7);
        restart(32'd0, 32'h009);
        ticks(2);
        rd_chk("R10 both flags", 4'd3, 32'h3);
        chk("R10 irq_ch", {28'h0, irq_ch}, 32'h3);
        rd_chk("R10 tc keeps counting", 4'd8, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_prescale();
        t_enable();
        t_irq();
        t_clear_match();
        t_halt();
        t_both();
        t_multi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule